// File: doc/BRIEF.md
# Ultra-DMA Operation Control and Status Unit

This unit is the register-side control for an Ultra-DMA transfer engine on a parallel disk interface. Software talks to it through a small word-wide register port with three registers: the operation register (enable and direction), the status register (raw and sticky conditions from the DMA state machine), and the interface line register (two chip selects and two strobes, all active low). The unit enforces a fixed arming protocol before the enable bit may take effect. It performs the cleanup when a transfer stops. It also drives a configuration word that selects Ultra-DMA timing while a transfer runs and PIO timing after one ends.

The unit also turns the status conditions and the device interrupt pin into a 2-bit transfer status for the host. An error outranks a pending interrupt, and a pending interrupt outranks activity. The burst protocol on the cable and the memory-side DMA channel sit outside this unit.

Register addresses are 0 for the operation register, 1 for the status register and 2 for the line register. Any other address reads as zero.

Top module: `udma_ctl_top`

## Requirements
- R1: After reset the operation register reads 0, the line outputs are 4'hF, the configuration word is 0, the protocol flag is 0 and the transfer status is idle (0).
- R2: The operation register holds enable at bit 0 and direction at bit 1 (1 means toward the device). The enable bit turns on only after three steps in this order: a write with bit 0 clear, a read of the operation register, and a write with bit 0 set and the same direction. The enable write then sets the configuration word to {udma_mode, 4'b1001}, where bit 0 is interface enable and bit 3 is Ultra-DMA.
- R3: A write with bit 0 set that does not complete the three steps of R2 (the read is missing or the direction differs) leaves the operation register unchanged. It sets the protocol flag, which is bit 31 of the status register and the proto_err output. The flag stays set until reset.
- R4: While enabled, a write with bit 0 set is ignored, so the direction cannot change.
- R5: While enabled, a write with bit 0 clear is a stop. It clears the operation register to 0, forces the line outputs to 4'hF and sets the configuration word to {pio_mode, 4'b0011}, where bit 1 is PIO.
- R6: The status register shows the DMA request at bit 16, the error interrupt at bit 17, the state machine busy at bit 18, data-out incomplete at bit 24, data-in incomplete at bit 25 and the non-multiple-of-four-words error at bit 26.
- R7: Status bits 17, 24, 25 and 26 are sticky. Once seen, each stays set until the next write of the operation register with bit 0 clear.
- R8: The transfer status is 3 (error) if any of status bits 17, 24, 25 or 26 is set. Otherwise it is 2 (interrupt) if intrq_in is high. Otherwise it is 1 (active) if bit 16 or bit 18 is set, and 0 (idle) if none of these apply.
- R9: A write to the line register sets the line outputs to wdata[3:0] (cs0_n, cs1_n, rd_n, wr_n from bit 0 up), and a read returns them.
- R10: A write of the operation register with bit 0 clear while not enabled stores the direction and restarts the arming sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| dma_req_in | input | 1 | DMA request from the transfer state machine |
| err_int_in | input | 1 | Error interrupt from the transfer state machine |
| busy_in | input | 1 | Transfer state machine not idle |
| dout_inc_in | input | 1 | Data-out incomplete error |
| din_inc_in | input | 1 | Data-in incomplete error |
| n4w_in | input | 1 | Count not a multiple of four words |
| intrq_in | input | 1 | Device interrupt pin |
| udma_mode | input | 4 | Ultra-DMA mode number used on enable |
| pio_mode | input | 4 | PIO mode number restored on stop |
| xfer_stat | output | 2 | Encoded transfer status |
| ide_lines | output | 4 | Active-low chip selects and strobes |
| cfg_word | output | 8 | Interface configuration word |
| proto_err | output | 1 | Sticky arming-protocol violation |

## Verification
A wrong arming state shows up in two ways. An early or missing enable appears on the operation readback, and a wrong configuration word appears on cfg_word, one cycle after the third step. A lost sticky error shows up right away as a drop of xfer_stat from 3 on the first cycle after the raw condition clears. A stop that misses cleanup leaves ide_lines or cfg_word wrong in the cycle after the stopping write. Random traffic often breaks the arming order on purpose, so proto_err and the ignored enables are checked against a cycle-accurate model on every cycle.

// File: rtl/udma_pkg.sv
package udma_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LINE_W = 4;

  localparam logic [1:0] A_OP    = 2'd0;
  localparam logic [1:0] A_STAT  = 2'd1;
  localparam logic [1:0] A_LINES = 2'd2;

  localparam int unsigned OP_EN  = 0;
  localparam int unsigned OP_DIR = 1;

  localparam int unsigned ST_DREQ = 16;
  localparam int unsigned ST_EINT = 17;
  localparam int unsigned ST_BUSY = 18;
  localparam int unsigned ST_NDO  = 24;
  localparam int unsigned ST_NDI  = 25;
  localparam int unsigned ST_N4X  = 26;
  localparam int unsigned ST_VIOL = 31;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DIR   = 2'd1,
    SEQ_ARMED = 2'd2,
    SEQ_RUN   = 2'd3
  } seq_t;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_ACT  = 2'd1,
    XS_INT  = 2'd2,
    XS_ERR  = 2'd3
  } xstat_t;
endpackage

// File: rtl/udma_seq.sv
module udma_seq
  import udma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic op_wr,
  input  logic op_rd,
  input  logic w_en,
  input  logic w_dir,
  output logic en_q,
  output logic dir_q,
  output logic viol_q,
  output logic start_p,
  output logic stop_p,
  output logic clr_err
);
  seq_t state_q, state_d;
  logic dir_d, viol_d;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    viol_d  = viol_q;
    start_p = 1'b0;
    stop_p  = 1'b0;
    if (state_q == SEQ_RUN) begin
      if (op_wr && !w_en) begin
        state_d = SEQ_IDLE;
        dir_d   = 1'b0;
        stop_p  = 1'b1;
      end
    end else if (op_wr) begin
      if (!w_en) begin
        state_d = SEQ_DIR;
        dir_d   = w_dir;
      end else if (state_q == SEQ_ARMED && w_dir == dir_q) begin
        state_d = SEQ_RUN;
        start_p = 1'b1;
      end else begin
        viol_d = 1'b1;
      end
    end else if (op_rd && state_q == SEQ_DIR) begin
      state_d = SEQ_ARMED;
    end
  end

  assign clr_err = op_wr && !w_en;
  assign en_q    = (state_q == SEQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      dir_q   <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      viol_q  <= viol_d;
    end
  end

  assert_en_after_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(op_wr && w_en && (w_dir == dir_q)));
  assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(dir_q));
  assert_viol_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(viol_q) |-> viol_q);
endmodule

// File: rtl/udma_stat.sv
module udma_stat
  import udma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] raw_word,
  input  logic              intrq,
  input  logic              viol,
  input  logic              clr,
  output logic [DATA_W-1:0] stat_word,
  output logic [1:0]        xstat
);
  localparam logic [DATA_W-1:0] ERR_MASK = (DATA_W'(1) << ST_EINT) | (DATA_W'(1) << ST_NDO)
                                         | (DATA_W'(1) << ST_NDI) | (DATA_W'(1) << ST_N4X);
  localparam logic [DATA_W-1:0] ACT_MASK = (DATA_W'(1) << ST_DREQ) | (DATA_W'(1) << ST_BUSY);

  logic [DATA_W-1:0] sticky_q, sticky_d;

  always_comb begin
    if (clr) sticky_d = '0;
    else     sticky_d = sticky_q | (raw_word & ERR_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_d;
  end

  always_comb begin
    stat_word          = raw_word | sticky_q;
    stat_word[ST_VIOL] = viol;
    if (|(stat_word & ERR_MASK))      xstat = XS_ERR;
    else if (intrq)                   xstat = XS_INT;
    else if (|(stat_word & ACT_MASK)) xstat = XS_ACT;
    else                              xstat = XS_IDLE;
  end

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_word[ST_NDO]) && !$past(clr)) |-> (xstat == XS_ERR));
endmodule

// File: rtl/udma_pinctl.sv
module udma_pinctl
  import udma_pkg::*;
#(
  parameter int unsigned MODE_W = 4,
  localparam int unsigned CFG_W = MODE_W + 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lines_wr,
  input  logic [LINE_W-1:0] lines_wdata,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [MODE_W-1:0] udma_mode,
  input  logic [MODE_W-1:0] pio_mode,
  output logic [LINE_W-1:0] lines_q,
  output logic [CFG_W-1:0]  cfg_q
);
  logic [LINE_W-1:0] lines_d;
  logic [CFG_W-1:0]  cfg_d;
  logic              lines_ce, cfg_ce;

  always_comb begin
    lines_ce = stop_p || lines_wr;
    lines_d  = stop_p ? {LINE_W{1'b1}} : lines_wdata;
    cfg_ce   = start_p || stop_p;
    cfg_d    = start_p ? {udma_mode, 4'b1001} : {pio_mode, 4'b0011};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= {LINE_W{1'b1}};
      cfg_q   <= '0;
    end else begin
      if (lines_ce) lines_q <= lines_d;
      if (cfg_ce)   cfg_q   <= cfg_d;
    end
  end

  assert_stop_cleanup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_p) |-> (lines_q == {LINE_W{1'b1}}) && (cfg_q[3:0] == 4'b0011));
endmodule

// File: rtl/udma_ctl_top.sv
module udma_ctl_top
  import udma_pkg::*;
#(
  parameter int unsigned MODE_W = 4
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 dma_req_in,
  input  logic                 err_int_in,
  input  logic                 busy_in,
  input  logic                 dout_inc_in,
  input  logic                 din_inc_in,
  input  logic                 n4w_in,
  input  logic                 intrq_in,
  input  logic [MODE_W-1:0]    udma_mode,
  input  logic [MODE_W-1:0]    pio_mode,
  output logic [1:0]           xfer_stat,
  output logic [LINE_W-1:0]    ide_lines,
  output logic [MODE_W+3:0]    cfg_word,
  output logic                 proto_err
);
  logic op_wr, op_rd, lines_wr;
  logic en_q, dir_q, viol_q, start_p, stop_p, clr_err;
  logic [DATA_W-1:0] raw_word, stat_word;
  logic unused_wdata;

  assign op_wr        = bus_wr && (bus_addr == A_OP);
  assign op_rd        = bus_rd && (bus_addr == A_OP);
  assign lines_wr     = bus_wr && (bus_addr == A_LINES);
  assign unused_wdata = ^bus_wdata[DATA_W-1:LINE_W];

  always_comb begin
    raw_word          = '0;
    raw_word[ST_DREQ] = dma_req_in;
    raw_word[ST_EINT] = err_int_in;
    raw_word[ST_BUSY] = busy_in;
    raw_word[ST_NDO]  = dout_inc_in;
    raw_word[ST_NDI]  = din_inc_in;
    raw_word[ST_N4X]  = n4w_in;
  end

  udma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_rd(op_rd),
    .w_en(bus_wdata[OP_EN]), .w_dir(bus_wdata[OP_DIR]),
    .en_q(en_q), .dir_q(dir_q), .viol_q(viol_q),
    .start_p(start_p), .stop_p(stop_p), .clr_err(clr_err)
  );

  udma_stat u_stat (
    .clk(clk), .rst_n(rst_n), .raw_word(raw_word), .intrq(intrq_in),
    .viol(viol_q), .clr(clr_err), .stat_word(stat_word), .xstat(xfer_stat)
  );

  udma_pinctl #(.MODE_W(MODE_W)) u_pin (
    .clk(clk), .rst_n(rst_n), .lines_wr(lines_wr),
    .lines_wdata(bus_wdata[LINE_W-1:0]), .start_p(start_p), .stop_p(stop_p),
    .udma_mode(udma_mode), .pio_mode(pio_mode),
    .lines_q(ide_lines), .cfg_q(cfg_word)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_OP:    begin bus_rdata[OP_EN] = en_q; bus_rdata[OP_DIR] = dir_q; end
      A_STAT:  bus_rdata = stat_word;
      A_LINES: bus_rdata[LINE_W-1:0] = ide_lines;
      default: bus_rdata = '0;
    endcase
  end

  assign proto_err = viol_q;
endmodule

// File: tb/udma_ctl_top_tb.sv
`timescale 1ns/1ps
module udma_ctl_top_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic dma_req_in, err_int_in, busy_in, dout_inc_in, din_inc_in, n4w_in, intrq_in;
  logic [3:0] udma_mode, pio_mode;
  logic [1:0] xfer_stat;
  logic [3:0] ide_lines;
  logic [7:0] cfg_word;
  logic proto_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_state;
  logic m_dir, m_viol;
  logic [31:0] m_sticky;
  logic [3:0] m_lines;
  logic [7:0] m_cfg;

  localparam logic [31:0] ERRM = 32'h0702_0000;
  localparam logic [31:0] ACTM = 32'h0005_0000;

  always #2 clk = ~clk;

  udma_ctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req_in(dma_req_in), .err_int_in(err_int_in), .busy_in(busy_in),
    .dout_inc_in(dout_inc_in), .din_inc_in(din_inc_in), .n4w_in(n4w_in),
    .intrq_in(intrq_in), .udma_mode(udma_mode), .pio_mode(pio_mode),
    .xfer_stat(xfer_stat), .ide_lines(ide_lines), .cfg_word(cfg_word),
    .proto_err(proto_err)
  );

  function automatic logic [31:0] raw_fn();
    return (32'(dma_req_in) << 16) | (32'(err_int_in) << 17) | (32'(busy_in) << 18)
         | (32'(dout_inc_in) << 24) | (32'(din_inc_in) << 25) | (32'(n4w_in) << 26);
  endfunction

  function automatic logic [31:0] stat_fn();
    return raw_fn() | m_sticky | (32'(m_viol) << 31);
  endfunction

  function automatic logic [1:0] enc_fn(input logic [31:0] w, input logic irq);
    if ((w & ERRM) != 0) return 2'd3;
    if (irq) return 2'd2;
    if ((w & ACTM) != 0) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [31:0] rd_fn(input logic [1:0] a);
    case (a)
      2'd0: return {30'd0, m_dir, (m_state == 3)};
      2'd1: return stat_fn();
      2'd2: return {28'd0, m_lines};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] d);
    logic opw;
    opw = wr && (a == 2'd0);
    if (opw && !d[0]) m_sticky = 32'd0;
    else m_sticky = m_sticky | (raw_fn() & ERRM);
    if (m_state == 3) begin
      if (opw && !d[0]) begin
        m_state = 0; m_dir = 1'b0; m_lines = 4'hF; m_cfg = {pio_mode, 4'b0011};
      end
    end else if (opw) begin
      if (!d[0]) begin m_state = 1; m_dir = d[1]; end
      else if (m_state == 2 && d[1] == m_dir) begin
        m_state = 3; m_cfg = {udma_mode, 4'b1001};
      end else m_viol = 1'b1;
    end else if (rd && a == 2'd0 && m_state == 1) m_state = 2;
    if (wr && a == 2'd2) m_lines = d[3:0];
  endtask

  // drive at negedge, check read data mid-cycle, update model at posedge, check outputs after it
  task automatic step(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    if (rd) check(bus_rdata, rd_fn(a), "R6/R9/R2 readback");
    @(posedge clk);
    model_edge(wr, rd, a, d);
    #1;
    check(32'(cfg_word), 32'(m_cfg), "R2/R5 cfg_word");
    check(32'(ide_lines), 32'(m_lines), "R5/R9 ide_lines");
    check(32'(proto_err), 32'(m_viol), "R3 proto_err");
    check(32'(xfer_stat), 32'(enc_fn(stat_fn(), intrq_in)), "R8 xfer_stat");
    bus_wr = 0; bus_rd = 0;
    @(negedge clk);
  endtask

  task automatic arm(input logic dir);
    step(1, 0, 2'd0, {30'd0, dir, 1'b0});
    step(0, 1, 2'd0, 32'd0);
    step(1, 0, 2'd0, {30'd0, dir, 1'b1});
  endtask

  task automatic set_raw(input logic [6:0] v);
    {intrq_in, n4w_in, din_inc_in, dout_inc_in, busy_in, err_int_in, dma_req_in} = v;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    set_raw(7'd0); udma_mode = 4'd5; pio_mode = 4'd2;
    m_state = 0; m_dir = 0; m_viol = 0; m_sticky = 0; m_lines = 4'hF; m_cfg = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(32'(ide_lines), 32'hF, "R1 lines");
    check(32'(cfg_word), 32'h0, "R1 cfg");
    check(32'(proto_err), 32'h0, "R1 proto_err");
    check(32'(xfer_stat), 32'h0, "R1 xfer_stat");
    step(0, 1, 2'd0, 32'd0);

    // R2 full arming sequence toward device, R10 restart via direction write
    step(1, 0, 2'd0, 32'h0);
    arm(1'b1);
    check(32'(cfg_word), 32'h59, "R2 cfg udma");
    step(0, 1, 2'd0, 32'd0);
    bus_addr = 2'd0; #1; check(bus_rdata, 32'h3, "R2 op enabled"); @(negedge clk);
    // R4 direction change while enabled ignored
    step(1, 0, 2'd0, 32'h1);
    bus_addr = 2'd0; #1; check(bus_rdata, 32'h3, "R4 dir held"); @(negedge clk);
    // R9 line write
    step(1, 0, 2'd2, 32'h6);
    check(32'(ide_lines), 32'h6, "R9 lines written");
    // R5 stop
    step(1, 0, 2'd0, 32'h2);
    check(32'(ide_lines), 32'hF, "R5 lines forced");
    check(32'(cfg_word), 32'h23, "R5 cfg pio");
    bus_addr = 2'd0; #1; check(bus_rdata, 32'h0, "R5 op cleared"); @(negedge clk);
    // R3 enable without read
    step(1, 0, 2'd0, 32'h0);
    step(1, 0, 2'd0, 32'h1);
    bus_addr = 2'd0; #1; check(bus_rdata, 32'h0, "R3 enable ignored"); @(negedge clk);
    check(32'(proto_err), 32'h1, "R3 flag set");
    // R6 bit positions, R7 sticky, R8 priority
    set_raw(7'b0000101);
    step(0, 1, 2'd1, 32'd0);
    bus_addr = 2'd1; #1; check(bus_rdata, 32'h8005_0000, "R6 active bits"); @(negedge clk);
    check(32'(xfer_stat), 32'h1, "R8 active");
    set_raw(7'b1000101);
    step(0, 0, 2'd1, 32'd0);
    check(32'(xfer_stat), 32'h2, "R8 interrupt over active");
    set_raw(7'b1111000);
    step(0, 0, 2'd1, 32'd0);
    set_raw(7'd0);
    #1; check(32'(xfer_stat), 32'h3, "R7 sticky error held");
    bus_addr = 2'd1; #1; check(bus_rdata, 32'h8700_0000, "R6/R7 sticky bits"); @(negedge clk);
    step(1, 0, 2'd0, 32'h0);
    check(32'(xfer_stat), 32'h0, "R7 cleared by op write");

    // random traffic with model
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if ($urandom_range(0, 7) == 0) begin
        logic [6:0] r;
        r = 7'($urandom());
        r[5:3] = r[5:3] & 3'($urandom()) & 3'($urandom());
        set_raw(r);
      end
      udma_mode = 4'($urandom()); pio_mode = 4'($urandom());
      case (k)
        0, 1:    step(1, 0, 2'd0, 32'($urandom_range(0, 3)));
        2, 3:    step(0, 1, 2'd0, 32'd0);
        4:       step(0, 1, 2'($urandom_range(1, 3)), 32'd0);
        5:       step(1, 0, 2'd2, 32'($urandom()));
        6, 7:    arm(1'($urandom()));
        default: step(0, 0, 2'd0, 32'd0);
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule